// File: doc/BRIEF.md
# Iterated 256-bit ARX Permutation Core

This core applies a keyless permutation to a 256-bit state. The state is treated as eight 32-bit words grouped into four (x, y) branches. A caller presents a state and a step count and pulses `start`. The core then runs one complete step on every clock cycle until the requested number of steps is done.

Each step has three phases. First, the step index and a table constant are folded into the first two y words. Next, four add-rotate-xor boxes run in parallel, one on each branch, and each box is keyed by a fixed constant. Last, a Feistel-style mixing layer combines the left half into the right half and then exchanges the halves with a one-branch rotation. When the last step is finished, `done` pulses for one cycle. The result remains on `state_out` until the next accepted start.

Top module: `perm256_core`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `state_out` is all zero.
- R2: At the start of step s, counting from 0, y1 is XORed with s zero-extended to 32 bits and y0 is XORed with constant[s mod 8]. The constant table is B7E15162, BF715880, 38B4DA56, 324E7738, BB1185EB, 4F7C7B57, CFBFA1C8, C2B3293D (hex, indices 0..7). State word k sits at bits [32k+31:32k] in the order x0, y0, x1, y1, x2, y2, x3, y3.
- R3: Branch i passes through a four-round box keyed by constant[i]. Each round does x += rotr(y,a), then y ^= rotr(x,b), then x ^= key. The (a, b) pairs for the four rounds are (31,24), (17,17), (0,31) and (24,16).
- R4: The mixing layer uses ell(t) = rotr(t ^ (t << 16), 16). It forms tx = ell(x0^x1) and ty = ell(y0^y1), XORs tx into y2 and y3, and XORs ty into x2 and x3.
- R5: The halves are then exchanged: new y0 = y3'^y1, new y1 = y2'^y0, new y2 = y0, new y3 = y1. The x words follow the same rule. Here y2' and y3' are the values after the XOR in R4.
- R6: Suppose a start with count N > 0 is taken at clock edge E0. Then `busy` is high from E0 to E_N, one step is applied at each edge E1..E_N, and `done` is high for the single cycle after E_N.
- R7: A start with count 0 never raises `busy`. `done` is high for the cycle after E0, and `state_out` equals `state_in` unchanged.
- R8: `done` lasts one cycle, and `busy` is low whenever `done` is high.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the running computation, its result, its completion cycle, or the number of `done` pulses.
- R10: While idle, `state_out` holds the last result unchanged.
- R11: The step count is captured at the accepted start. Changes on `steps` during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a permutation when idle |
| steps | input | STEP_W (4) | Number of steps to apply |
| state_in | input | 256 | Initial state, word k at bits [32k+31:32k] |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse: result valid |
| state_out | output | 256 | Current / final state |

## Verification
For each stimulus, the result is due in a cycle that depends only on its step count. If start is taken at edge E0, `done` must appear in the cycle after edge E_N, or after E0 itself when N is 0. The driver computes that cycle number from the running edge count and queues it together with the model's expected state. The monitor samples on falling edges and compares both the state and the arrival cycle whenever `done` is seen, so a result that arrives one cycle early or late is reported. A second start issued in the middle of a run must not add a queue entry or a `done` pulse, and the original entry must still arrive on its original cycle.

// File: rtl/perm256_pkg.sv
package perm256_pkg;
  localparam int WORD_W  = 32;
  localparam int NBRANCH = 4;
  localparam int NWORD   = 2 * NBRANCH;
  localparam int STATE_W = NWORD * WORD_W;
  localparam int NCONST  = 8;
  localparam int NROUND  = 4;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(word_t v, int unsigned r);
    logic [2*WORD_W-1:0] d;
    d = {v, v} >> r;
    return d[WORD_W-1:0];
  endfunction

  function automatic word_t ell(word_t t);
    return rotr(t ^ (t << 16), 16);
  endfunction

  function automatic word_t round_const(logic [2:0] idx);
    case (idx)
      3'd0:    return 32'hB7E15162;
      3'd1:    return 32'hBF715880;
      3'd2:    return 32'h38B4DA56;
      3'd3:    return 32'h324E7738;
      3'd4:    return 32'hBB1185EB;
      3'd5:    return 32'h4F7C7B57;
      3'd6:    return 32'hCFBFA1C8;
      default: return 32'hC2B3293D;
    endcase
  endfunction

  // rotation applied to y before the add, per round
  function automatic int unsigned add_rot(int r);
    case (r)
      0:       return 31;
      1:       return 17;
      2:       return 0;
      default: return 24;
    endcase
  endfunction

  // rotation applied to x before the xor into y, per round
  function automatic int unsigned xor_rot(int r);
    case (r)
      0:       return 24;
      1:       return 17;
      2:       return 31;
      default: return 16;
    endcase
  endfunction

  function automatic word_t get_word(logic [STATE_W-1:0] s, int k);
    return s[k*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/perm256_inject.sv
module perm256_inject
  import perm256_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic [STATE_W-1:0] st_in,
  input  logic [STEP_W-1:0]  step_idx,
  output logic [STATE_W-1:0] st_out
);
  localparam int Y0_IDX = 1;
  localparam int Y1_IDX = 3;

  word_t y0_key;
  word_t y1_key;

  assign y0_key = round_const(step_idx[2:0]);
  assign y1_key = WORD_W'(step_idx);

  always_comb begin
    st_out = st_in;
    st_out[Y0_IDX*WORD_W +: WORD_W] = get_word(st_in, Y0_IDX) ^ y0_key;
    st_out[Y1_IDX*WORD_W +: WORD_W] = get_word(st_in, Y1_IDX) ^ y1_key;
  end
endmodule

// File: rtl/perm256_arxbox.sv
module perm256_arxbox
  import perm256_pkg::*;
#(
  parameter int BRANCH = 0
) (
  input  word_t x_in,
  input  word_t y_in,
  output word_t x_out,
  output word_t y_out
);
  localparam word_t KEY = round_const(3'(BRANCH));

  always_comb begin : rounds
    word_t xv;
    word_t yv;
    xv = x_in;
    yv = y_in;
    for (int r = 0; r < NROUND; r++) begin
      xv = xv + rotr(yv, add_rot(r));
      yv = yv ^ rotr(xv, xor_rot(r));
      xv = xv ^ KEY;
    end
    x_out = xv;
    y_out = yv;
  end
endmodule

// File: rtl/perm256_linear.sv
module perm256_linear
  import perm256_pkg::*;
(
  input  logic [STATE_W-1:0] st_in,
  output logic [STATE_W-1:0] st_out
);
  word_t xi [NBRANCH];
  word_t yi [NBRANCH];
  word_t tx, ty;
  word_t x2m, x3m, y2m, y3m;

  for (genvar b = 0; b < NBRANCH; b++) begin : g_unpack
    assign xi[b] = get_word(st_in, 2*b);
    assign yi[b] = get_word(st_in, 2*b + 1);
  end

  assign tx  = ell(xi[0] ^ xi[1]);
  assign ty  = ell(yi[0] ^ yi[1]);
  assign y2m = yi[2] ^ tx;
  assign y3m = yi[3] ^ tx;
  assign x2m = xi[2] ^ ty;
  assign x3m = xi[3] ^ ty;

  // half exchange with one-branch rotation of the right half
  assign st_out = {yi[1], xi[1],          // y3, x3
                   yi[0], xi[0],          // y2, x2
                   y2m ^ yi[0], x2m ^ xi[0], // y1, x1
                   y3m ^ yi[1], x3m ^ xi[1]}; // y0, x0
endmodule

// File: rtl/perm256_ctrl.sv
module perm256_ctrl #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] steps,
  output logic              busy,
  output logic              done,
  output logic              load,
  output logic [STEP_W-1:0] step_idx
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  logic              busy_q, done_q;
  logic [STEP_W-1:0] cnt_q, steps_q;
  logic              start_fire;
  logic              last_step;
  logic              zero_req;

  assign start_fire = start && !busy_q;
  assign zero_req   = start_fire && (steps == '0);
  assign last_step  = busy_q && (cnt_q == steps_q - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      steps_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_fire) begin
        steps_q <= steps;
        cnt_q   <= '0;
        if (zero_req) done_q <= 1'b1;
        else          busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + ONE;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign load     = start_fire;
  assign step_idx = cnt_q;

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  p_last_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (done_q && !busy_q));
  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> (busy_q && cnt_q == $past(cnt_q) + ONE));
  p_zero_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (done_q && !busy_q));
  p_count_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(steps_q));
endmodule

// File: rtl/perm256_core.sv
module perm256_core
  import perm256_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [STEP_W-1:0]    steps,
  input  logic [STATE_W-1:0]   state_in,
  output logic                 busy,
  output logic                 done,
  output logic [STATE_W-1:0]   state_out
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] inj_st, arx_st, lin_st;
  logic               load;
  logic [STEP_W-1:0]  step_idx;

  perm256_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .steps    (steps),
    .busy     (busy),
    .done     (done),
    .load     (load),
    .step_idx (step_idx)
  );

  perm256_inject #(.STEP_W(STEP_W)) u_inject (
    .st_in    (state_q),
    .step_idx (step_idx),
    .st_out   (inj_st)
  );

  for (genvar b = 0; b < NBRANCH; b++) begin : g_box
    perm256_arxbox #(.BRANCH(b)) u_box (
      .x_in  (inj_st[(2*b)*WORD_W   +: WORD_W]),
      .y_in  (inj_st[(2*b+1)*WORD_W +: WORD_W]),
      .x_out (arx_st[(2*b)*WORD_W   +: WORD_W]),
      .y_out (arx_st[(2*b+1)*WORD_W +: WORD_W])
    );
  end

  perm256_linear u_linear (
    .st_in  (arx_st),
    .st_out (lin_st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= '0;
    else if (load) state_q <= state_in;
    else if (busy) state_q <= lin_st;
  end

  assign state_out = state_q;

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !busy) |=> $stable(state_q));
  p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state_q == $past(state_in)));
endmodule

// File: tb/test_perm256_core.sv
module test_perm256_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   steps = '0;
  logic [255:0] state_in = '0;
  logic         busy, done;
  logic [255:0] state_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [255:0] exp_q [$];
  int           due_q [$];

  perm256_core i_perm256_core (
    .clk(clk), .rst_n(rst_n), .start(start), .steps(steps),
    .state_in(state_in), .busy(busy), .done(done), .state_out(state_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- independent model ----------------
  function automatic bit [31:0] kc(int i);
    bit [31:0] t [8] = '{32'hB7E15162, 32'hBF715880, 32'h38B4DA56, 32'h324E7738,
                         32'hBB1185EB, 32'h4F7C7B57, 32'hCFBFA1C8, 32'hC2B3293D};
    return t[i % 8];
  endfunction

  function automatic bit [31:0] rl(bit [31:0] v, int k);
    if (k == 0) return v;
    return (v << k) | (v >> (32 - k));
  endfunction

  function automatic bit [31:0] halfswap_mix(bit [31:0] t);
    bit [31:0] u;
    u = t ^ {t[15:0], 16'h0};
    return {u[15:0], u[31:16]};
  endfunction

  function automatic logic [255:0] model(logic [255:0] s, int n);
    bit [31:0] w [8];
    bit [31:0] x, y, tx, ty;
    bit [31:0] o [8];
    int ra [4] = '{31, 17, 0, 24};
    int rb [4] = '{24, 17, 31, 16};
    logic [255:0] r;
    for (int k = 0; k < 8; k++) w[k] = s[32*k +: 32];
    for (int st = 0; st < n; st++) begin
      w[3] ^= st;
      w[1] ^= kc(st);
      for (int b = 0; b < 4; b++) begin
        x = w[2*b]; y = w[2*b+1];
        for (int q = 0; q < 4; q++) begin
          x = x + rl(y, (32 - ra[q]) % 32);
          y = y ^ rl(x, (32 - rb[q]) % 32);
          x = x ^ kc(b);
        end
        w[2*b] = x; w[2*b+1] = y;
      end
      tx = halfswap_mix(w[0] ^ w[2]);
      ty = halfswap_mix(w[1] ^ w[3]);
      o[0] = w[6] ^ ty ^ w[2];
      o[1] = w[7] ^ tx ^ w[3];
      o[2] = w[4] ^ ty ^ w[0];
      o[3] = w[5] ^ tx ^ w[1];
      o[4] = w[0]; o[5] = w[1]; o[6] = w[2]; o[7] = w[3];
      w = o;
    end
    for (int k = 0; k < 8; k++) r[32*k +: 32] = w[k];
    return r;
  endfunction

  function automatic logic [255:0] rnd_state();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  // ---------------- reporting ----------------
  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R6 act=hung exp=done");
    summary();
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 256'(cyc), 256'(0));
      end else begin
        logic [255:0] e;
        int due;
        e = exp_q.pop_front();
        due = due_q.pop_front();
        chk(state_out === e, "R2 R3 R4 R5 result", state_out, e);
        chk(cyc == due, "R6 done cycle", 256'(cyc), 256'(due));
        chk(!busy, "R8 busy low with done", 256'(busy), 256'(0));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(logic [255:0] s, int n);
    @(negedge clk);
    start = 1'b1; state_in = s; steps = 4'(n);
    exp_q.push_back(model(s, n));
    due_q.push_back(cyc + 1 + n);
    @(negedge clk);
    start = 1'b0; state_in = rnd_state(); steps = 4'($urandom);
  endtask

  task automatic run(logic [255:0] s, int n);
    logic [255:0] e;
    bit saw = 0;
    e = model(s, n);
    issue(s, n);
    while (!done) begin
      saw |= busy;
      @(negedge clk);
    end
    if (n == 0) begin
      chk(!saw, "R7 busy stayed low", 256'(saw), 256'(0));
      chk(state_out === s, "R7 unchanged state", state_out, s);
    end
    @(negedge clk);
    chk(!done, "R8 single-cycle done", 256'(done), 256'(0));
    chk(state_out === e, "R10 result held", state_out, e);
    repeat (3) @(negedge clk);
    chk(state_out === e, "R10 result still held", state_out, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && state_out == '0, "R1 in reset",
        {state_out[253:0], busy, done}, 256'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && state_out == '0, "R1 after reset",
        {state_out[253:0], busy, done}, 256'(0));

    run('0, 1);                         // R2 R3 R4 R5 from zero state
    run(rnd_state(), 0);                // R7
    run({8{32'hFFFFFFFF}}, 2);
    foreach (steps_list[i]) run(rnd_state(), steps_list[i]);

    // R9 R11: mid-run start and count change are ignored
    begin
      logic [255:0] s0, e0;
      s0 = rnd_state();
      e0 = model(s0, 10);
      issue(s0, 10);
      repeat (2) @(negedge clk);
      start = 1'b1; state_in = rnd_state(); steps = 4'd2;
      repeat (2) @(negedge clk);
      start = 1'b0; steps = 4'd15;
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(state_out === e0, "R9 R11 run unaffected", state_out, e0);
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0 && !busy, "R9 no extra run",
          256'(exp_q.size()), 256'(0));
    end

    run(rnd_state(), 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results arrived", 256'(exp_q.size()), 256'(0));
    summary();
  end

  int steps_list [10] = '{1, 3, 7, 8, 9, 10, 11, 15, 10, 7};
endmodule